// File: doc/BRIEF.md
# Retrace Line-Count Bias Sequencer

This block schedules a picture-tube cutoff calibration once per frame, inside vertical blanking. It runs on a fast system clock and takes the vertical and horizontal sync inputs asynchronously. Each sync input passes through a two-flop synchroniser and a rising-edge detector. A vertical edge arms the sequencer and clears a line counter. Each horizontal edge after that advances the counter by one line.

Fixed line numbers in that count set four controls. The auto-bias output forces the video path to black. The grid pulse raises cathode current to the reference level. The program pulse is active low and marks the sense window. A two-bit mode code sets the shared sample/hold switch of all three colour channels to open, set-up or sense. A one-cycle strobe marks the line where sense ends, which is the point at which a channel latches its correction. The line counter saturates so that it cannot wrap. A line timeout disarms the sequencer when vertical sync is missing.

Top module: `retrace_bias_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs sit at their inactive levels: autobias_o=0, grid_o=0, prog_o=1, mode_o=2'b00, latch_o=0.
- R2: For lines 1 to 13 counted after a vertical edge, and on the vertical edge itself (line 0), all outputs are inactive.
- R3: autobias_o is 1 from line 14 through line 20, which is seven lines, and is 0 from line 21 on.
- R4: mode_o is 2'b01 (set-up) on lines 15, 16 and 17. grid_o is 1 on exactly those lines and 0 on all others.
- R5: mode_o is 2'b10 (sense) on lines 18, 19 and 20. prog_o is 0 on exactly those lines and 1 on all others.
- R6: mode_o is 2'b00 (open) outside lines 15 to 20 and never takes the value 2'b11. Because the line counter saturates, hundreds of further lines without a vertical edge never restart the sequence.
- R7: latch_o pulses high for exactly one clock, once per armed frame, when line 21 is counted.
- R8: A vertical edge in the middle of a sequence returns all outputs to inactive and restarts the count at line 0.
- R9: When TIMEOUT_LINES lines have been counted since the last vertical edge, the sequencer disarms. From that line on, all outputs stay inactive and latch_o does not pulse until the next vertical edge.
- R10: After reset and before the first vertical edge, horizontal edges produce no output activity.
- R11: A horizontal input held high for many clocks counts as one line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, asynchronous, active high |
| hsync_i | input | 1 | Horizontal sync, asynchronous, active high |
| autobias_o | output | 1 | Black-level force pulse, active high |
| grid_o | output | 1 | Grid pulse, high during set-up |
| prog_o | output | 1 | Program pulse, low during sense |
| mode_o | output | 2 | Sample/hold switch mode: 00 open, 01 set-up, 10 sense |
| latch_o | output | 1 | One-clock strobe at the end of sense |

## Verification
The assertions assume that each sync pulse, and each gap between pulses, lasts at least a few system clocks, so every rising edge gets through the synchroniser. They also assume that a vertical edge and a horizontal edge never reach the counter in the same clock. The stimulus keeps to both assumptions: each line is eight clocks long with a three-clock high phase, and the vertical pulse sits between lines. A second instance built with a short timeout covers the disarm path, because the default limit is far beyond the window of the sequence.

// File: rtl/retrace_pkg.sv
package retrace_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN  = 2'b00,
    MODE_SETUP = 2'b01,
    MODE_SENSE = 2'b10
  } bias_mode_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/retrace_sync_edge.sv
module retrace_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/retrace_line_cnt.sv
module retrace_line_cnt #(
  parameter int unsigned LW            = 5,
  parameter int unsigned LINE_MAX      = 21,
  parameter int unsigned TIMEOUT_LINES = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          line_i,
  output logic [LW-1:0] line_o,
  output logic          adv_o,
  output logic          armed_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_LINES + 1);
  localparam logic [LW-1:0] LMAX  = LW'(LINE_MAX);
  localparam logic [TW-1:0] TMAX  = TW'(TIMEOUT_LINES);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_LINES - 1);

  logic [LW-1:0] line_q;
  logic [TW-1:0] to_q;
  logic          adv_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      to_q    <= '0;
      adv_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (frame_i) begin
      // vertical edge wins over a coincident horizontal edge
      line_q  <= '0;
      to_q    <= '0;
      adv_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (line_i) begin
      adv_q <= (line_q != LMAX);
      if (line_q != LMAX) line_q <= line_q + 1'b1;
      if (to_q != TMAX)   to_q   <= to_q + 1'b1;
      if (to_q == TLAST)  armed_q <= 1'b0;
    end else begin
      adv_q <= 1'b0;
    end
  end

  assign line_o  = line_q;
  assign adv_o   = adv_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/retrace_phase_dec.sv
module retrace_phase_dec
  import retrace_pkg::*;
#(
  parameter int unsigned LW          = 5,
  parameter int unsigned AB_START    = 14,
  parameter int unsigned AB_LINES    = 7,
  parameter int unsigned SETUP_LINES = 3,
  parameter int unsigned SENSE_LINES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] line_i,
  input  logic          adv_i,
  input  logic          armed_i,
  output logic          autobias_o,
  output logic          grid_o,
  output logic          prog_o,
  output logic [1:0]    mode_o,
  output logic          latch_o
);
  localparam logic [LW-1:0] AB_S = LW'(AB_START);
  localparam logic [LW-1:0] AB_E = LW'(AB_START + AB_LINES);
  localparam logic [LW-1:0] SU_S = LW'(AB_START + 1);
  localparam logic [LW-1:0] SN_S = LW'(AB_START + 1 + SETUP_LINES);
  localparam logic [LW-1:0] SN_E = LW'(AB_START + 1 + SETUP_LINES + SENSE_LINES);

  logic       ab_d, setup_d, sense_d, latch_d;
  bias_mode_e mode_d, mode_q;
  logic       ab_q, grid_q, prog_q, latch_q;

  always_comb begin
    ab_d    = armed_i && (line_i >= AB_S) && (line_i < AB_E);
    setup_d = armed_i && (line_i >= SU_S) && (line_i < SN_S);
    sense_d = armed_i && (line_i >= SN_S) && (line_i < SN_E);
    latch_d = armed_i && adv_i && (line_i == SN_E);
    if (sense_d)      mode_d = MODE_SENSE;
    else if (setup_d) mode_d = MODE_SETUP;
    else              mode_d = MODE_OPEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q    <= 1'b0;
      grid_q  <= 1'b0;
      prog_q  <= 1'b1;
      mode_q  <= MODE_OPEN;
      latch_q <= 1'b0;
    end else begin
      ab_q    <= ab_d;
      grid_q  <= setup_d;
      prog_q  <= ~sense_d;
      mode_q  <= mode_d;
      latch_q <= latch_d;
    end
  end

  assign autobias_o = ab_q;
  assign grid_o     = grid_q;
  assign prog_o     = prog_q;
  assign mode_o     = mode_q;
  assign latch_o    = latch_q;
endmodule

// File: rtl/retrace_bias_seq.sv
module retrace_bias_seq
  import retrace_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned AB_START      = 14,
  parameter int unsigned AB_LINES      = 7,
  parameter int unsigned SETUP_LINES   = 3,
  parameter int unsigned SENSE_LINES   = 3,
  parameter int unsigned TIMEOUT_LINES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vsync_i,
  input  logic       hsync_i,
  output logic       autobias_o,
  output logic       grid_o,
  output logic       prog_o,
  output logic [1:0] mode_o,
  output logic       latch_o
);
  localparam int unsigned NSYNC    = 2;
  localparam int unsigned LINE_MAX = max_u(AB_START + AB_LINES,
                                           AB_START + 1 + SETUP_LINES + SENSE_LINES);
  localparam int unsigned LW       = $clog2(LINE_MAX + 1);

  logic [NSYNC-1:0] sync_raw;
  logic [NSYNC-1:0] sync_rise;
  logic [LW-1:0]    line;
  logic             adv, armed;

  assign sync_raw = {hsync_i, vsync_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    retrace_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sync_raw[g]),
      .rise_o (sync_rise[g])
    );
  end

  retrace_line_cnt #(
    .LW(LW), .LINE_MAX(LINE_MAX), .TIMEOUT_LINES(TIMEOUT_LINES)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (sync_rise[0]),
    .line_i  (sync_rise[1]),
    .line_o  (line),
    .adv_o   (adv),
    .armed_o (armed)
  );

  retrace_phase_dec #(
    .LW(LW), .AB_START(AB_START), .AB_LINES(AB_LINES),
    .SETUP_LINES(SETUP_LINES), .SENSE_LINES(SENSE_LINES)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line),
    .adv_i      (adv),
    .armed_i    (armed),
    .autobias_o (autobias_o),
    .grid_o     (grid_o),
    .prog_o     (prog_o),
    .mode_o     (mode_o),
    .latch_o    (latch_o)
  );
endmodule

// File: rtl/retrace_bias_seq_chk.sv
module retrace_bias_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       autobias_o,
  input logic       grid_o,
  input logic       prog_o,
  input logic [1:0] mode_o,
  input logic       latch_o
);
  p_mode_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  p_open_not_sense_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b00 |=> mode_o != 2'b10);

  p_grid_in_ab_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_o |-> autobias_o);

  p_prog_in_ab_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_o |-> autobias_o);

  p_grid_prog_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grid_o && !prog_o));

  p_latch_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);

  p_latch_after_sense_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> ($past(mode_o) == 2'b10 && mode_o == 2'b00));
endmodule

bind retrace_bias_seq retrace_bias_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .autobias_o (autobias_o),
  .grid_o     (grid_o),
  .prog_o     (prog_o),
  .mode_o     (mode_o),
  .latch_o    (latch_o)
);

// File: tb/retrace_bias_seq_tb.sv
module retrace_bias_seq_tb;
  localparam int TO_B = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vs = 1'b0;
  logic hs = 1'b0;
  logic       a_ab, a_grid, a_prog, a_latch;
  logic [1:0] a_mode;
  logic       b_ab, b_grid, b_prog, b_latch;
  logic [1:0] b_mode;

  int checks = 0;
  int failures = 0;
  int lat_a = 0;
  int lat_b = 0;
  bit framed = 1'b0;

  always #10 clk = ~clk;

  retrace_bias_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vs), .hsync_i(hs),
    .autobias_o(a_ab), .grid_o(a_grid), .prog_o(a_prog),
    .mode_o(a_mode), .latch_o(a_latch)
  );

  retrace_bias_seq #(.TIMEOUT_LINES(TO_B)) u_dut_to (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vs), .hsync_i(hs),
    .autobias_o(b_ab), .grid_o(b_grid), .prog_o(b_prog),
    .mode_o(b_mode), .latch_o(b_latch)
  );

  always @(negedge clk) begin
    if (a_latch) lat_a++;
    if (b_latch) lat_b++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // expected values from line number n and armed state
  task automatic check_dut(string who, int n, bit armed, string ovr,
                           logic ab, logic grid, logic prog, logic [1:0] mode, int dlat);
    int em;
    bit eab;
    string tm;
    eab = armed && n >= 14 && n <= 20;
    em  = !armed ? 0 : (n >= 18 && n <= 20) ? 2 : (n >= 15 && n <= 17) ? 1 : 0;
    if (n < 14)      tm = "R2";
    else if (n < 18) tm = "R4";
    else if (n < 21) tm = "R5";
    else             tm = "R6";
    if (!armed && n >= 14) tm = "R9";
    chk(ovr != "" ? ovr : "R3", $sformatf("%s autobias line %0d", who, n), int'(ab), int'(eab));
    chk(ovr != "" ? ovr : tm,   $sformatf("%s mode line %0d", who, n), int'(mode), em);
    chk(ovr != "" ? ovr : "R4", $sformatf("%s grid line %0d", who, n), int'(grid), int'(em == 1));
    chk(ovr != "" ? ovr : "R5", $sformatf("%s prog line %0d", who, n), int'(prog), int'(em != 2));
    chk(ovr != "" ? ovr : "R7", $sformatf("%s latch line %0d", who, n), dlat,
        int'(armed && n == 21));
  endtask

  task automatic check_both(int n, string ovr, int la0, int lb0);
    check_dut("a", n, framed && n < 1024, ovr, a_ab, a_grid, a_prog, a_mode, lat_a - la0);
    check_dut("b", n, framed && n < TO_B, ovr, b_ab, b_grid, b_prog, b_mode, lat_b - lb0);
  endtask

  task automatic hline();
    @(negedge clk) hs = 1'b1;
    repeat (3) @(negedge clk);
    hs = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic vpulse();
    int la0, lb0;
    la0 = lat_a; lb0 = lat_b;
    @(negedge clk) vs = 1'b1;
    repeat (4) @(negedge clk);
    vs = 1'b0;
    repeat (4) @(negedge clk);
    framed = 1'b1;
    check_both(0, "R2", la0, lb0);
  endtask

  task automatic run_lines(int from, int upto, string ovr);
    for (int n = from; n <= upto; n++) begin
      int la0, lb0;
      la0 = lat_a; lb0 = lat_b;
      hline();
      check_both(n, ovr, la0, lb0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check_both(0, "R1", lat_a, lat_b);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_both(0, "R1", lat_a, lat_b);

    // R10: lines before the first vertical edge
    run_lines(1, 25, "R10");

    // R2..R7: full frame, then R6 saturation over many lines
    vpulse();
    run_lines(1, 30, "");
    run_lines(31, 330, "R6");

    // R8: restart during sense
    vpulse();
    run_lines(1, 19, "");
    vpulse();
    check_both(0, "R8", lat_a, lat_b);
    run_lines(1, 24, "");

    // R11: held horizontal input counts one line
    vpulse();
    run_lines(1, 13, "");
    begin
      int la0, lb0;
      la0 = lat_a; lb0 = lat_b;
      @(negedge clk) hs = 1'b1;
      repeat (40) @(negedge clk);
      hs = 1'b0;
      repeat (5) @(negedge clk);
      check_both(14, "R11", la0, lb0);
    end
    run_lines(15, 23, "");

    // second frame after timeout on instance b: rearmed (R9)
    vpulse();
    run_lines(1, 22, "");

    report();
    $finish;
  end
endmodule